// File: doc/BRIEF.md
# SRAM Sleep Entry and Exit Sequencer

This block sits on the controller side of a synchronous pipelined SRAM. It handles the move into the memory's low-power sleep state and the move back out. A client asks for sleep by holding `sleep_req` high. The sequencer then stops taking new commands. It waits until every read or write already sent to the memory has left the memory's pipeline, and only then raises the asynchronous, active-high `sleep_pin`. While the memory settles into sleep, and again for a fixed number of cycles after the pin drops, the memory may only see read or deselect cycles. The sequencer lets those through and holds writes back with ready low, so that no write is lost.

The upstream command port uses valid/ready. The downstream port drives one command to the SRAM every cycle, and it sends a deselect whenever nothing may or does pass. `sleep_gnt` tells the client that the memory is asleep. `wake_done` marks the first cycle after the recovery window. The pin never toggles inside a timing window. A wake request that arrives while the pin is still settling is served only after sleep has been fully reached.

Top module: `sram_sleep_seq`

## Requirements
- R1: Reset state. While `rst_n` is low and in the first cycle after it is released, `sleep_pin`, `sleep_gnt` and `wake_done` are low, `up_ready` is high, and `dn_cmd` is deselect (00) whenever `up_valid` is low.
- R2: When the block is awake and `sleep_req` is low, `up_ready` is high. The command codes are 00 deselect, 01 read, 10 write and 11 reserved. An accepted read or write appears on `dn_cmd` in the same cycle, with `dn_addr` equal to `up_addr`. Code 11, or `up_valid` low, drives deselect.
- R3: Once the block sees `sleep_req` high at an edge, `up_ready` is low from that edge on and `dn_cmd` is deselect. If a read or write was issued at edge k, the pin stays low through edge k+RD_LAT and rises at edge k+RD_LAT+1. With nothing in flight, the pin rises one edge after the drain starts.
- R4: During the setup window of SETUP_CYC cycles after the pin rises, `sleep_gnt` stays low. A write is held with `up_ready` low and `dn_cmd` deselect, while a read is accepted and forwarded.
- R5: After the setup window, `sleep_gnt` and `sleep_pin` are high for as long as `sleep_req` stays high. In that time `up_ready` is low and `dn_cmd` is deselect for any input.
- R6: If `sleep_req` falls during the setup window, the pin stays high for the whole window and `sleep_gnt` still goes high for one cycle before the exit starts.
- R7: The pin falls at the first edge at which the sleeping block sees `sleep_req` low. A recovery window of RECOVER_CYC cycles follows. In it, writes are held with `up_ready` low and `dn_cmd` deselect, reads are forwarded, and `wake_done` stays low.
- R8: `wake_done` is high for exactly one cycle, the first cycle after the recovery window. In that same cycle `up_ready` is high and writes pass again.
- R9: If `sleep_req` falls while the block is still draining, the block returns to normal operation at the next edge without raising the pin, and `up_ready` goes high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the SRAM |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Level request: high asks for sleep, low asks for wake |
| sleep_gnt | output | 1 | High while the memory is fully asleep |
| wake_done | output | 1 | One-cycle pulse when normal operation resumes |
| up_valid | input | 1 | Upstream command valid |
| up_ready | output | 1 | Upstream command accepted this cycle |
| up_cmd | input | 2 | Upstream command: 00 deselect, 01 read, 10 write, 11 reserved |
| up_addr | input | ADDR_W | Upstream address |
| dn_cmd | output | 2 | Command to the SRAM, same encoding as `up_cmd` |
| dn_addr | output | ADDR_W | Address to the SRAM |
| sleep_pin | output | 1 | Asynchronous active-high sleep pin to the SRAM |

## Verification
The bench issues a read on the very edge that the sleep request is first seen. It then checks that the pin stays low for the full read latency. A design that counted occupancy one cycle short would raise the pin while that read was still inside the memory. Writes and reads are offered in every setup and recovery cycle. A design that dropped held writes, or let one through, would show a write on `dn_cmd` or ready high where it must be low. Wake requests are dropped in mid-setup and in mid-drain, which catches a pin toggled inside its window or a drain that does not abort. The bench also checks the exact cycle of the `wake_done` pulse and its width, so a pulse one cycle early, one cycle late or held too long is reported.

// File: rtl/sram_sleep_pkg.sv
// Shared types of the SRAM sleep sequencer.
// Assumes a 2-bit command code that both the upstream and downstream ports use.
package sram_sleep_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_SETUP   = 3'd2,
        ST_SLEEP   = 3'd3,
        ST_RECOVER = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        GATE_OPEN    = 2'd0,
        GATE_NOWRITE = 2'd1,
        GATE_CLOSED  = 2'd2
    } gate_e;

endpackage

// File: rtl/sss_occupancy.sv
// Tracks read/write cycles that are still inside the SRAM pipeline.
// A shift register of RD_LAT bits is marked each time a read or write is issued.
// The pipeline is busy while any bit is set.
// Assumes RD_LAT >= 1.
module sss_occupancy #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic busy
);

    logic [RD_LAT-1:0] pipe_q;

    generate
        if (RD_LAT == 1) begin : g_single
            // Holds the one cycle of occupancy.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= issue;
            end
        end else begin : g_shift
            // Ages each issued cycle by one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[RD_LAT-2:0], issue};
            end
        end
    endgenerate

    // Busy while any stage still holds an issued cycle.
    always_comb busy = |pipe_q;

endmodule

// File: rtl/sss_window_timer.sv
// Down-counter for the setup and recovery windows.
// Loading a value N makes expired go high N cycles later.
// The count holds at zero once it gets there.
module sss_window_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Loads on request and otherwise counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // The window has ended once the count is zero.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/sss_cmd_gate.sv
// Filters upstream commands on their way to the SRAM, according to the gate mode.
// OPEN passes everything. NOWRITE holds writes back and passes reads or deselects.
// CLOSED accepts nothing.
// Whatever is not accepted goes downstream as a deselect.
// The reserved code is accepted but forwarded as a deselect.
module sss_cmd_gate
    import sram_sleep_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  gate_e             gate,
    input  logic              up_valid,
    input  logic [1:0]        up_cmd,
    input  logic [ADDR_W-1:0] up_addr,
    output logic              up_ready,
    output logic [1:0]        dn_cmd,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              issue
);

    logic fire;
    logic is_rw;

    // Ready follows the gate mode and, in NOWRITE, the offered command.
    always_comb begin
        case (gate)
            GATE_OPEN:    up_ready = 1'b1;
            GATE_NOWRITE: up_ready = (up_cmd != CMD_WRITE);
            default:      up_ready = 1'b0;
        endcase
    end

    // An accepted read or write reaches the SRAM. Anything else becomes a deselect.
    always_comb begin
        fire    = up_valid && up_ready;
        is_rw   = (up_cmd == CMD_READ) || (up_cmd == CMD_WRITE);
        dn_cmd  = (fire && is_rw) ? up_cmd : CMD_DESEL;
        dn_addr = up_addr;
        issue   = fire && is_rw;
    end

endmodule

// File: rtl/sss_fsm.sv
// Sleep sequencing state machine: ACTIVE, DRAIN, SETUP, SLEEP, RECOVER, then ACTIVE.
// The sleep pin, grant and wake pulse come straight from flops, so the
// asynchronous pin never glitches.
// Assumes SETUP_CYC >= 1 and RECOVER_CYC >= 1.
module sss_fsm
    import sram_sleep_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int RECOVER_CYC = 2,
    parameter int CNT_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             busy,
    input  logic             expired,
    output gate_e            gate,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sleep_pin,
    output logic             sleep_gnt,
    output logic             wake_done
);

    localparam logic [CNT_W-1:0] SETUP_VAL   = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] RECOVER_VAL = CNT_W'(RECOVER_CYC - 1);

    state_e state_q, state_d;

    // Next state, plus the timer load when a window opens.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_ACTIVE:  if (sleep_req) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (!sleep_req) state_d = ST_ACTIVE;
                else if (!busy) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_VAL;
                end
            end
            ST_SETUP:   if (expired) state_d = ST_SLEEP;
            ST_SLEEP: begin
                if (!sleep_req) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = RECOVER_VAL;
                end
            end
            ST_RECOVER: if (expired) state_d = ST_ACTIVE;
            default:    state_d = ST_ACTIVE;
        endcase
    end

    // Command gate mode for each state.
    always_comb begin
        case (state_q)
            ST_ACTIVE:  gate = GATE_OPEN;
            ST_SETUP,
            ST_RECOVER: gate = GATE_NOWRITE;
            default:    gate = GATE_CLOSED;
        endcase
    end

    // State register and the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_ACTIVE;
            sleep_pin <= 1'b0;
            sleep_gnt <= 1'b0;
            wake_done <= 1'b0;
        end else begin
            state_q   <= state_d;
            sleep_pin <= (state_d == ST_SETUP) || (state_d == ST_SLEEP);
            sleep_gnt <= (state_d == ST_SLEEP);
            wake_done <= (state_q == ST_RECOVER) && (state_d == ST_ACTIVE);
        end
    end

endmodule

// File: rtl/sram_sleep_seq.sv
// Top of the SRAM sleep sequencer.
// Joins the state machine, the window timer, the pipeline occupancy tracker and
// the command gate.
// Assumes the SRAM keeps a read or write in its pipeline for RD_LAT cycles after
// the issue edge.
module sram_sleep_seq
    import sram_sleep_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int RD_LAT      = 2,
    parameter int SETUP_CYC   = 2,
    parameter int RECOVER_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    output logic              sleep_gnt,
    output logic              wake_done,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [1:0]        up_cmd,
    input  logic [ADDR_W-1:0] up_addr,
    output logic [1:0]        dn_cmd,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              sleep_pin
);

    localparam int MAX_WIN = (SETUP_CYC > RECOVER_CYC) ? SETUP_CYC : RECOVER_CYC;
    localparam int CNT_W   = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;

    gate_e            gate;
    logic             occ_busy;
    logic             issue;
    logic             tmr_load;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    sss_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .RECOVER_CYC(RECOVER_CYC),
        .CNT_W      (CNT_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .busy     (occ_busy),
        .expired  (tmr_expired),
        .gate     (gate),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .sleep_pin(sleep_pin),
        .sleep_gnt(sleep_gnt),
        .wake_done(wake_done)
    );

    sss_window_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    sss_occupancy #(.RD_LAT(RD_LAT)) i_occ (
        .clk  (clk),
        .rst_n(rst_n),
        .issue(issue),
        .busy (occ_busy)
    );

    sss_cmd_gate #(.ADDR_W(ADDR_W)) i_gate (
        .gate    (gate),
        .up_valid(up_valid),
        .up_cmd  (up_cmd),
        .up_addr (up_addr),
        .up_ready(up_ready),
        .dn_cmd  (dn_cmd),
        .dn_addr (dn_addr),
        .issue   (issue)
    );

endmodule

// File: rtl/sss_chk.sv
// Assertion checker for sram_sleep_seq. It is bound into the top module below.
// It watches the ports and the occupancy flag.
module sss_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_pin,
    input logic       sleep_gnt,
    input logic       wake_done,
    input logic       up_valid,
    input logic       up_ready,
    input logic [1:0] up_cmd,
    input logic [1:0] dn_cmd,
    input logic       busy
);

    // R3
    pin_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_pin) |-> $past(!busy));

    // R4
    no_write_under_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_pin |-> (dn_cmd != 2'b10));

    // R4
    no_write_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && up_cmd == 2'b10) |-> !sleep_pin);

    // R5
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_gnt |-> (dn_cmd == 2'b00 && !up_ready && sleep_pin));

    // R6
    pin_fall_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_pin) |-> $past(sleep_gnt));

    // R7
    recover_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_pin) |-> (dn_cmd != 2'b10 && !wake_done));

    // R8
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    // R8
    wake_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (up_ready && !sleep_pin));

endmodule

bind sram_sleep_seq sss_chk i_sss_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_pin(sleep_pin),
    .sleep_gnt(sleep_gnt),
    .wake_done(wake_done),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .up_cmd   (up_cmd),
    .dn_cmd   (dn_cmd),
    .busy     (occ_busy)
);

// File: tb/test_sram_sleep_seq.sv
`timescale 1ns/1ps
// Directed bench for sram_sleep_seq, with one task per scenario.
// Inputs change at the falling edge. Outputs are sampled 1 ns later.
module test_sram_sleep_seq;

    localparam int ADDR_W = 19;
    localparam logic [1:0] DES = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sleep_req;
    logic              sleep_gnt;
    logic              wake_done;
    logic              up_valid;
    logic              up_ready;
    logic [1:0]        up_cmd;
    logic [ADDR_W-1:0] up_addr;
    logic [1:0]        dn_cmd;
    logic [ADDR_W-1:0] dn_addr;
    logic              sleep_pin;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sram_sleep_seq #(.ADDR_W(ADDR_W)) i_sram_sleep_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .sleep_gnt(sleep_gnt),
        .wake_done(wake_done),
        .up_valid (up_valid),
        .up_ready (up_ready),
        .up_cmd   (up_cmd),
        .up_addr  (up_addr),
        .dn_cmd   (dn_cmd),
        .dn_addr  (dn_addr),
        .sleep_pin(sleep_pin)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Goes to the next falling edge, drives the inputs, then waits 1 ns.
    task automatic cyc(input logic req, input logic v, input logic [1:0] c,
                       input logic [ADDR_W-1:0] a);
        @(negedge clk);
        sleep_req = req;
        up_valid  = v;
        up_cmd    = c;
        up_addr   = a;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, DES, '0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        sleep_req = 1'b0; up_valid = 1'b0; up_cmd = DES; up_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "pin in reset",  sleep_pin, 1'b0);
        chk("R1", "gnt in reset",  sleep_gnt, 1'b0);
        chk("R1", "done in reset", wake_done, 1'b0);
        chk("R1", "ready in reset", up_ready, 1'b1);
        chk("R1", "dn idle",       dn_cmd, DES);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, DES, '0);
        chk("R1", "pin after reset", sleep_pin, 1'b0);
        chk("R1", "ready after reset", up_ready, 1'b1);
        idle(2);
    endtask

    task automatic test_passthrough();
        cyc(1'b0, 1'b1, WR, 19'h1abcd);
        chk("R2", "ready write", up_ready, 1'b1);
        chk("R2", "dn write", dn_cmd, WR);
        chk("R2", "dn addr", dn_addr, 19'h1abcd);
        cyc(1'b0, 1'b1, RSV, 19'h00042);
        chk("R2", "ready reserved", up_ready, 1'b1);
        chk("R2", "dn reserved", dn_cmd, DES);
        cyc(1'b0, 1'b0, RD, 19'h00042);
        chk("R2", "dn not valid", dn_cmd, DES);
        idle(4);
    endtask

    task automatic test_full_cycle();
        cyc(1'b1, 1'b1, RD, 19'h00155);          // edge k: read issued
        chk("R2", "read at req edge", dn_cmd, RD);
        chk("R2", "addr at req edge", dn_addr, 19'h00155);
        cyc(1'b1, 1'b1, WR, '0);
        chk("R3", "drain ready", up_ready, 1'b0);
        chk("R3", "drain dn", dn_cmd, DES);
        chk("R3", "pin k+1", sleep_pin, 1'b0);
        cyc(1'b1, 1'b0, DES, '0);
        chk("R3", "pin k+2", sleep_pin, 1'b0);
        cyc(1'b1, 1'b0, DES, '0);
        chk("R3", "pin k+2 hold", sleep_pin, 1'b0);
        cyc(1'b1, 1'b1, WR, '0);
        chk("R3", "pin k+3", sleep_pin, 1'b1);
        chk("R4", "gnt setup1", sleep_gnt, 1'b0);
        chk("R4", "setup write ready", up_ready, 1'b0);
        chk("R4", "setup write dn", dn_cmd, DES);
        cyc(1'b1, 1'b1, RD, 19'h0002a);
        chk("R4", "setup read ready", up_ready, 1'b1);
        chk("R4", "setup read dn", dn_cmd, RD);
        chk("R4", "gnt setup2", sleep_gnt, 1'b0);
        cyc(1'b1, 1'b1, RD, '0);
        chk("R5", "gnt sleep", sleep_gnt, 1'b1);
        chk("R5", "pin sleep", sleep_pin, 1'b1);
        chk("R5", "sleep ready", up_ready, 1'b0);
        chk("R5", "sleep dn", dn_cmd, DES);
        cyc(1'b1, 1'b1, WR, '0);
        chk("R5", "gnt sleep hold", sleep_gnt, 1'b1);
        chk("R5", "sleep dn write", dn_cmd, DES);
        cyc(1'b0, 1'b1, RD, '0);
        chk("R5", "gnt before exit edge", sleep_gnt, 1'b1);
        chk("R5", "pin before exit edge", sleep_pin, 1'b1);
        cyc(1'b0, 1'b1, WR, '0);
        chk("R7", "pin fell", sleep_pin, 1'b0);
        chk("R7", "gnt fell", sleep_gnt, 1'b0);
        chk("R7", "recover write ready", up_ready, 1'b0);
        chk("R7", "recover write dn", dn_cmd, DES);
        chk("R7", "no early done", wake_done, 1'b0);
        cyc(1'b0, 1'b1, RD, 19'h00077);
        chk("R7", "recover read ready", up_ready, 1'b1);
        chk("R7", "recover read dn", dn_cmd, RD);
        chk("R7", "no early done 2", wake_done, 1'b0);
        cyc(1'b0, 1'b1, WR, 19'h0003c);
        chk("R8", "done pulse", wake_done, 1'b1);
        chk("R8", "ready back", up_ready, 1'b1);
        chk("R8", "write back", dn_cmd, WR);
        cyc(1'b0, 1'b0, DES, '0);
        chk("R8", "done one cycle", wake_done, 1'b0);
        idle(4);
    endtask

    task automatic test_wake_in_setup();
        cyc(1'b1, 1'b0, DES, '0);
        cyc(1'b1, 1'b0, DES, '0);
        chk("R3", "empty drain pin low", sleep_pin, 1'b0);
        cyc(1'b0, 1'b0, DES, '0);
        chk("R3", "empty drain pin rose", sleep_pin, 1'b1);
        chk("R6", "gnt setup", sleep_gnt, 1'b0);
        cyc(1'b0, 1'b0, DES, '0);
        chk("R6", "pin held in setup", sleep_pin, 1'b1);
        cyc(1'b0, 1'b0, DES, '0);
        chk("R6", "gnt reached", sleep_gnt, 1'b1);
        chk("R6", "pin at sleep", sleep_pin, 1'b1);
        cyc(1'b0, 1'b0, DES, '0);
        chk("R7", "pin exit", sleep_pin, 1'b0);
        chk("R6", "gnt one cycle", sleep_gnt, 1'b0);
        cyc(1'b0, 1'b0, DES, '0);
        chk("R7", "done waits window", wake_done, 1'b0);
        cyc(1'b0, 1'b0, DES, '0);
        chk("R8", "done after window", wake_done, 1'b1);
        idle(4);
    endtask

    task automatic test_drain_abort();
        cyc(1'b1, 1'b0, DES, '0);
        cyc(1'b0, 1'b1, WR, 19'h00011);
        chk("R9", "drain stall", up_ready, 1'b0);
        chk("R9", "drain dn", dn_cmd, DES);
        cyc(1'b0, 1'b1, WR, 19'h00011);
        chk("R9", "ready after abort", up_ready, 1'b1);
        chk("R9", "write after abort", dn_cmd, WR);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b0, DES, '0);
            chk("R9", "pin stays low", sleep_pin, 1'b0);
            chk("R9", "gnt stays low", sleep_gnt, 1'b0);
        end
    endtask

    initial begin
        test_reset();
        test_passthrough();
        test_full_cycle();
        test_wake_in_setup();
        test_drain_abort();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule